// File: doc/BRIEF.md
# Embedded-Operation Status Byte Generator

This block decides what byte a read returns while a memory controller runs an internal program or erase operation. The controller reports when an operation starts, its kind, the top bit of the byte being programmed, which erase sectors are selected, whether the sector-add window is still open, and whether the operation failed or finished. While an operation is active, the block replaces array data on the read path with a status byte. That byte carries a data-polling bit, a toggle bit that flips once per read access, an error bit and an erase-started bit. When the operation ends, reads return the true array data again.

Two cases get special handling. During erase suspend, only reads of sectors that are being erased see status; reads of every other sector see array data. An erase whose sectors are all protected erases nothing, and reports busy for a fixed number of cycles with the toggle bit held at zero.

Top module: `emb_status_gen`

## Requirements
- R1: After reset, `busy_o` is 0 and `dout` equals `array_data`.
- R2: During a program operation, the status byte is bit 7 = inverse of `prog_msb`, bit 6 = toggle, bit 5 = error, and bits 4..0 = 0.
- R3: During an erase operation, the status byte is bit 7 = 0, bit 6 = toggle, bit 5 = error, bit 3 = inverse of `erase_window`, and bits 4, 2, 1, 0 = 0.
- R4: Each rising edge of `rd_en` that returns status flips bit 6, and the new value is visible one clock later. Holding `rd_en` high does not flip bit 6 again.
- R5: A pulse on `op_fail` sets bit 5 to 1 until the operation ends. A new operation starts with bit 5 at 0.
- R6: The clock after `op_done`, `busy_o` is 0, every read returns `array_data`, and reads no longer change the toggle.
- R7: A start with `all_prot` set gives exactly `PROT_CYCLES` cycles of `busy_o`. During those cycles reads return 8'h08 (bits 7 and 6 at 0, bit 3 at 1), the toggle does not move, and `op_done` has no effect. After that, reads return `array_data`.
- R8: While an erase is active and `suspend` is high, a read of a selected sector returns bit 7 = 1, bit 6 = toggle, and all other bits 0, and it flips the toggle. A read of an unselected sector returns `array_data` and does not flip the toggle.
- R9: An erase selects `sect_id` at start. `sect_add` adds `sect_id` to the selection only while `erase_window` is high. Adds made after the window closes are ignored.
- R10: Status appears the clock after `op_start`, which the controller asserts on the final write strobe of a sequence. An `op_start` that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Pulse: an operation begins |
| op_erase | input | 1 | Operation kind at start: 1 erase, 0 program |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| all_prot | input | 1 | At start: every selected sector is protected |
| sect_id | input | SECTOR_W | Sector given at start or with an add |
| sect_add | input | 1 | Pulse: add `sect_id` to the erase selection |
| erase_window | input | 1 | High while more sectors may still be added |
| op_fail | input | 1 | Pulse: the operation failed |
| op_done | input | 1 | Pulse: the operation finished |
| suspend | input | 1 | Erase is suspended |
| rd_en | input | 1 | Read enable, active high |
| rd_sector | input | SECTOR_W | Sector of the current read address |
| array_data | input | 8 | Byte read from the array |
| dout | output | 8 | Byte returned to the reader |
| busy_o | output | 1 | Status mode or protected-erase pulse is active |

## Verification
Wrong internal state shows up at the ports within one read access. A toggle that is stuck or flips twice shows as two equal bit-6 values on back-to-back reads, or as a value that changes during a held read. A wrong sector selection shows up on the first suspended read of that sector, which returns array data where status was expected, or the reverse. A wrong protected-pulse counter shows up as a busy length that differs from `PROT_CYCLES`. A stale error or operation flag shows up as a nonzero bit 5 on the first read of the next operation, or as status returned after `op_done`.

// File: rtl/emb_status_gen.sv
module emb_status_gen #(
  parameter int SECTOR_W    = 3,
  parameter int PROT_CYCLES = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_start,
  input  logic                op_erase,
  input  logic                prog_msb,
  input  logic                all_prot,
  input  logic [SECTOR_W-1:0] sect_id,
  input  logic                sect_add,
  input  logic                erase_window,
  input  logic                op_fail,
  input  logic                op_done,
  input  logic                suspend,
  input  logic                rd_en,
  input  logic [SECTOR_W-1:0] rd_sector,
  input  logic [7:0]          array_data,
  output logic [7:0]          dout,
  output logic                busy_o
);
  localparam int NSECT = 1 << SECTOR_W;
  localparam int CNT_W = $clog2(PROT_CYCLES + 1);

  logic             op_act, is_erase, pbit, err, tog, rd_q;
  logic [NSECT-1:0] mask;
  logic [CNT_W-1:0] prot_cnt;

  logic       prot_act, susp_mode, status_on, rd_edge;
  logic [7:0] stat_byte;

  assign prot_act  = prot_cnt != '0;
  assign susp_mode = op_act & is_erase & suspend;
  assign status_on = prot_act | (op_act & (~susp_mode | mask[rd_sector]));
  assign rd_edge   = rd_en & ~rd_q;
  assign busy_o    = op_act | prot_act;

  always_comb begin
    if (prot_act)      stat_byte = 8'h08;
    else if (susp_mode) stat_byte = {1'b1, tog, 6'b0};
    else if (is_erase) stat_byte = {1'b0, tog, err, 1'b0, ~erase_window, 3'b0};
    else               stat_byte = {~pbit, tog, err, 5'b0};
  end

  assign dout = status_on ? stat_byte : array_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_act   <= 1'b0;
      is_erase <= 1'b0;
      pbit     <= 1'b0;
      err      <= 1'b0;
      tog      <= 1'b0;
      rd_q     <= 1'b0;
      mask     <= '0;
      prot_cnt <= '0;
    end else begin
      rd_q <= rd_en;
      if (op_start && !busy_o) begin
        if (all_prot) begin
          prot_cnt <= CNT_W'(PROT_CYCLES);
          tog      <= 1'b0;
        end else begin
          op_act   <= 1'b1;
          is_erase <= op_erase;
          pbit     <= prog_msb;
          err      <= 1'b0;
          mask     <= op_erase ? (NSECT'(1) << sect_id) : '0;
        end
      end else begin
        if (prot_act) prot_cnt <= prot_cnt - 1'b1;
        if (op_act) begin
          if (sect_add && is_erase && erase_window) mask[sect_id] <= 1'b1;
          if (op_fail) err <= 1'b1;
          if (op_done) begin
            op_act <= 1'b0;
            err    <= 1'b0;
          end
          if (rd_edge && status_on) tog <= ~tog;
        end
      end
    end
  end

  assert_held_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_q) |=> $stable(tog));

  assert_prot_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_act |=> !tog);

  assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_act && op_done) |=> !busy_o);

  assert_fresh_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !busy_o) |=> !err);

  assert_closed_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_act && !erase_window) |=> $stable(mask));

  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_act && op_start && !op_done) |=> (op_act && $stable(pbit) && $stable(is_erase)));
endmodule

// File: tb/emb_status_gen_tb.sv
module emb_status_gen_tb;
  localparam int SW = 3;
  localparam int PC = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_erase = 0, prog_msb = 0, all_prot = 0;
  logic [SW-1:0] sect_id = '0, rd_sector = '0;
  logic sect_add = 0, erase_window = 0, op_fail = 0, op_done = 0, suspend = 0, rd_en = 0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] dout;
  logic busy_o;

  int checks = 0;
  int errors = 0;
  bit exp_tog = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  emb_status_gen #(.SECTOR_W(SW), .PROT_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
    .prog_msb(prog_msb), .all_prot(all_prot), .sect_id(sect_id), .sect_add(sect_add),
    .erase_window(erase_window), .op_fail(op_fail), .op_done(op_done), .suspend(suspend),
    .rd_en(rd_en), .rd_sector(rd_sector), .array_data(array_data),
    .dout(dout), .busy_o(busy_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [SW-1:0] sec, output logic [7:0] v);
    @(negedge clk) rd_sector = sec; rd_en = 1'b1;
    @(negedge clk) v = dout; rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic start(input logic er, input logic msb, input logic [SW-1:0] s, input logic pr);
    @(negedge clk) op_start = 1'b1; op_erase = er; prog_msb = msb; sect_id = s; all_prot = pr;
    @(negedge clk) op_start = 1'b0; all_prot = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk) op_done = 1'b1;
    @(negedge clk) op_done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v, v2;
    array_data = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R1 dout after reset", dout, 8'h5A);
    chk("R1 busy after reset", {7'b0, busy_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dout idle", dout, 8'h5A);

    for (int d = 0; d < 256; d++) begin
      logic e;
      array_data = 8'(d) ^ 8'h3C;
      e = 1'b0;
      start(1'b0, d[7], '0, 1'b0);
      chk("R10 busy after start", {7'b0, busy_o}, 8'h01);
      rd(SW'(d), v);
      exp_tog = ~exp_tog;
      chk("R2 program status", v, {~d[7], exp_tog, 6'b0});
      if (d % 3 == 1) begin
        @(negedge clk) op_fail = 1'b1;
        @(negedge clk) op_fail = 1'b0;
        e = 1'b1;
      end
      rd(SW'(d + 1), v);
      exp_tog = ~exp_tog;
      chk("R4 R5 second read", v, {~d[7], exp_tog, e, 5'b0});
      if (d == 7) begin
        start(1'b0, ~d[7], '0, 1'b0);
        rd('0, v);
        exp_tog = ~exp_tog;
        chk("R10 start while busy ignored", v, {~d[7], exp_tog, e, 5'b0});
      end
      if (d == 9) begin
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) v = dout;
        exp_tog = ~exp_tog;
        repeat (3) @(negedge clk);
        chk("R4 held read stable", dout, v);
        rd_en = 1'b0;
        chk("R4 held read value", v, {~d[7], exp_tog, e, 5'b0});
      end
      pulse_done();
      chk("R6 busy clear", {7'b0, busy_o}, 8'h00);
      rd('0, v);
      rd('0, v2);
      chk("R6 array after done", v, 8'(d) ^ 8'h3C);
      chk("R6 repeated read equal", v2, v);
    end

    start(1'b0, 1'b1, '0, 1'b0);
    rd('0, v);
    exp_tog = ~exp_tog;
    chk("R5 new op error clear", v, {1'b0, exp_tog, 6'b0});
    pulse_done();

    for (int s = 0; s < (1 << SW); s++) begin
      logic [SW-1:0] s0, s1, s2;
      logic e;
      s0 = SW'(s); s1 = SW'(s + 3); s2 = SW'(s + 5);
      e = (s == 2);
      array_data = 8'(8'hA0 + s);
      @(negedge clk) erase_window = 1'b1;
      start(1'b1, 1'b0, s0, 1'b0);
      @(negedge clk) sect_id = s1; sect_add = 1'b1;
      @(negedge clk) sect_add = 1'b0;
      if (e) begin
        @(negedge clk) op_fail = 1'b1;
        @(negedge clk) op_fail = 1'b0;
      end
      rd(s2, v);
      exp_tog = ~exp_tog;
      chk("R3 erase window open", v, {1'b0, exp_tog, e, 5'b0});
      @(negedge clk) erase_window = 1'b0;
      @(negedge clk) sect_id = s2; sect_add = 1'b1;
      @(negedge clk) sect_add = 1'b0;
      rd(s0, v);
      exp_tog = ~exp_tog;
      chk("R3 erase started", v, {1'b0, exp_tog, e, 1'b0, 1'b1, 3'b0});
      @(negedge clk) suspend = 1'b1;
      for (int r = 0; r < (1 << SW); r++) begin
        rd(SW'(r), v);
        if (SW'(r) == s0 || SW'(r) == s1) begin
          exp_tog = ~exp_tog;
          chk("R8 R9 suspended selected", v, {1'b1, exp_tog, 6'b0});
        end else begin
          chk("R8 R9 suspended other", v, 8'(8'hA0 + s));
        end
      end
      @(negedge clk) suspend = 1'b0;
      rd(s2, v);
      exp_tog = ~exp_tog;
      chk("R8 resume status", v, {1'b0, exp_tog, e, 1'b0, 1'b1, 3'b0});
      pulse_done();
      rd(s0, v);
      chk("R6 erase done array", v, 8'(8'hA0 + s));
    end

    array_data = 8'h77;
    start(1'b1, 1'b0, 3'd4, 1'b1);
    begin
      int cnt;
      cnt = 0;
      while (busy_o && cnt < 1000) begin
        cnt++;
        if (cnt == 3) begin
          op_done = 1'b1;
          v = dout;
        end else op_done = 1'b0;
        if (cnt == 5) rd_en = 1'b1;
        if (cnt == 6) v2 = dout;
        if (cnt == 7) rd_en = 1'b0;
        if (cnt == 10) rd_en = 1'b1;
        if (cnt == 11) begin
          chk("R7 second read during pulse", dout, 8'h08);
          rd_en = 1'b0;
        end
        @(negedge clk);
      end
      op_done = 1'b0;
      chk("R7 pulse length", 8'(cnt), 8'(PC));
      chk("R7 status during pulse", v, 8'h08);
      chk("R7 read during pulse", v2, 8'h08);
      rd('0, v);
      chk("R7 array after pulse", v, 8'h77);
    end
    exp_tog = 1'b0;
    start(1'b0, 1'b0, '0, 1'b0);
    rd('0, v);
    exp_tog = ~exp_tog;
    chk("R7 toggle restarts from zero", v, {1'b1, exp_tog, 6'b0});
    pulse_done();

    summary();
  end
endmodule